// File: doc/BRIEF.md
# Qualified-Write Acquisition Control Register

This block is the write side of an 8-bit control register for a data-acquisition sequencer, together with the state it governs. A bus master selects the register through an address decode, raises a write strobe and presents a data byte. The three low data bits are clear commands for three event flip-flops: interrupt, external trigger and external interrupt. A write with one of these bits high starts a clear pulse of fixed length that ends by itself. While the pulse lasts, it holds the matching flip-flop cleared.

The three high bits hold sticky configuration: an arm bit for the post-trigger sample counter, a post-mode select and the pacer time-base select. They sit behind a two-level lock. A separate one-bit mode register must first select enhanced operation. Only then can bit 4 of the control byte, the extend qualifier, be set. Only while extend is already set does a write load the high bits.

Software therefore takes four separate writes to change a high bit. It sets the mode, sets extend, writes the high bits while keeping extend high, and then drops extend while repeating the high bits it wants to keep. A read-back byte exposes the whole state.

Top module: `acq_ctl_reg`

## Requirements
- R1: After reset, rd_data is 0x00, every clear pulse is low, the mode bit, extend and the three sticky bits are 0, and all event flags are 0.
- R2: A control write (ctl_sel and wr_en high) with data bit 0, 1 or 2 high clears event flag 0 (interrupt), 1 (external trigger) or 2 (external interrupt) at that clock edge. A data bit of 0 in those positions leaves the matching flag unchanged.
- R3: A control write with data bit i high drives clr_pulse[i] high from that edge for exactly PULSE_CYC cycles. PULSE_CYC is ceil(CLK_MHZ*PULSE_NS/1000). A new such write during the pulse restarts the full length.
- R4: While clr_pulse[i] is high, a high evt_set[i] does not set event flag i, because the clear wins.
- R5: A high evt_set[i] with no clear active or commanded sets event flag i at the next edge, and the flag stays set until it is cleared.
- R6: A mode write (mode_sel and wr_en high) loads the mode bit from data bit 4. The mode bit reads back at rd_data bit 3.
- R7: A control write loads extend from data bit 4 only while the mode bit is 1. With the mode bit at 0, extend is unchanged.
- R8: A control write loads the sticky bits from data bits 7:5 (bit 5 arm, bit 6 post-mode, bit 7 pacer) only if extend was already 1 before that write. Otherwise the sticky bits are unchanged.
- R9: The clear bits act on every control write, in both modes, including a write whose purpose is to change extend or the sticky bits.
- R10: The armed, post_mode and pacer_fast outputs follow sticky bits 5, 6 and 7. pacer_fast at 1 selects the 10 MHz time base and at 0 selects 1 MHz.
- R11: The rd_data fields are: bits 7:5 the sticky bits, bit 4 extend, bit 3 the mode bit, bits 2:0 the event flags. Data bit 3 of a control write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_sel | input | 1 | Address decode hit for the control register |
| mode_sel | input | 1 | Address decode hit for the mode register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data byte |
| evt_set | input | 3 | Set inputs of the three event flip-flops |
| clr_pulse | output | 3 | Active self-timed clear pulses |
| evt_flag | output | 3 | Event flip-flop states |
| armed | output | 1 | Post-trigger counting enable |
| post_mode | output | 1 | Counter start source select |
| pacer_fast | output | 1 | Pacer time base, 1 = 10 MHz, 0 = 1 MHz |
| rd_data | output | 8 | Read-back of the register state |

## Verification
The hardest state to reach from the ports is a change of a sticky bit. It needs a mode write followed by two ordered control writes, and random bytes rarely produce that order. A directed sequence therefore walks the unlock order step by step and also tries each step out of order. The random phase weights mode writes toward setting bit 4 and keeps control writes frequent, so that extend is regularly open while random data lands on bits 7:5. A set event that arrives inside a running clear pulse also needs exact timing. Directed steps raise evt_set during a pulse, on its last cycle and on the cycle just after it ends.

// File: rtl/acq_ctl_pkg.sv
package acq_ctl_pkg;

    localparam int DW       = 8;
    localparam int N_EVT    = 3;
    localparam int B_EXT    = 4;
    localparam int B_ARM    = 5;
    localparam int B_POST   = 6;
    localparam int B_PACE   = 7;
    localparam int B_MODE   = 4;
    localparam int RB_MODE  = 3;

    typedef struct packed {
        logic pacer_fast;
        logic post_mode;
        logic armed;
    } sticky_t;

    typedef struct packed {
        logic    mode;
        logic    extend;
        sticky_t sticky;
    } cfg_t;

    function automatic int pulse_cycles(input int clk_mhz, input int pulse_ns);
        return (clk_mhz * pulse_ns + 999) / 1000;
    endfunction

    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

    function automatic logic [DW-1:0] pack_readback(input cfg_t c,
                                                    input logic [N_EVT-1:0] f);
        logic [DW-1:0] r;
        r                 = '0;
        r[N_EVT-1:0]      = f;
        r[RB_MODE]        = c.mode;
        r[B_EXT]          = c.extend;
        r[B_PACE:B_ARM]   = c.sticky;
        return r;
    endfunction

endpackage

// File: rtl/acq_clr_timer.sv
module acq_clr_timer #(
    parameter int CYC = 188,
    parameter int W   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= W'(CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/acq_event_ff.sv
module acq_event_ff (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_now,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (clr_now) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end
    end
endmodule

// File: rtl/acq_cfg_regs.sv
module acq_cfg_regs
    import acq_ctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_wr,
    input  logic          ctl_wr,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg
);
    cfg_t cfg_q, cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (mode_wr) begin
            cfg_d.mode = wdata[B_MODE];
        end
        if (ctl_wr && cfg_q.mode) begin
            cfg_d.extend = wdata[B_EXT];
        end
        if (ctl_wr && cfg_q.extend) begin
            cfg_d.sticky = sticky_t'(wdata[B_PACE:B_ARM]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/acq_ctl_reg.sv
module acq_ctl_reg
    import acq_ctl_pkg::*;
#(
    parameter int CLK_MHZ  = 125,
    parameter int PULSE_NS = 1500
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctl_sel,
    input  logic         mode_sel,
    input  logic         wr_en,
    input  logic [7:0]   wr_data,
    input  logic [2:0]   evt_set,
    output logic [2:0]   clr_pulse,
    output logic [2:0]   evt_flag,
    output logic         armed,
    output logic         post_mode,
    output logic         pacer_fast,
    output logic [7:0]   rd_data
);
    localparam int PULSE_CYC = pulse_cycles(CLK_MHZ, PULSE_NS);
    localparam int CNT_W     = cnt_width(PULSE_CYC);

    logic             ctl_wr;
    logic             mode_wr;
    logic [N_EVT-1:0] clr_cmd;
    logic [N_EVT-1:0] clr_active;
    logic [N_EVT-1:0] flag_q;
    cfg_t             cfg;

    assign ctl_wr  = ctl_sel  & wr_en;
    assign mode_wr = mode_sel & wr_en;
    assign clr_cmd = {N_EVT{ctl_wr}} & wr_data[N_EVT-1:0];

    acq_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .mode_wr (mode_wr),
        .ctl_wr  (ctl_wr),
        .wdata   (wr_data),
        .cfg     (cfg)
    );

    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        acq_clr_timer #(
            .CYC (PULSE_CYC),
            .W   (CNT_W)
        ) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .start  (clr_cmd[i]),
            .active (clr_active[i])
        );

        acq_event_ff u_ff (
            .clk     (clk),
            .rst     (rst),
            .set_evt (evt_set[i]),
            .clr_now (clr_cmd[i] | clr_active[i]),
            .flag    (flag_q[i])
        );
    end

    assign clr_pulse  = clr_active;
    assign evt_flag   = flag_q;
    assign armed      = cfg.sticky.armed;
    assign post_mode  = cfg.sticky.post_mode;
    assign pacer_fast = cfg.sticky.pacer_fast;
    assign rd_data    = pack_readback(cfg, flag_q);
endmodule

// File: rtl/acq_ctl_chk.sv
module acq_ctl_chk
    import acq_ctl_pkg::*;
#(
    parameter int CLK_MHZ  = 125,
    parameter int PULSE_NS = 1500
) (
    input logic       clk,
    input logic       rst,
    input logic       ctl_sel,
    input logic       mode_sel,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [2:0] evt_set,
    input logic [2:0] clr_pulse,
    input logic [2:0] evt_flag,
    input logic       armed,
    input logic       post_mode,
    input logic       pacer_fast,
    input logic [7:0] rd_data
);
    localparam int PULSE_CYC = pulse_cycles(CLK_MHZ, PULSE_NS);

    logic ctl_wr;
    assign ctl_wr = ctl_sel & wr_en;

    // R1: reset state visible at the ports
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (rd_data == 8'h00 && clr_pulse == 3'b000));

    for (genvar i = 0; i < N_EVT; i++) begin : g_chk
        int unsigned run_len;

        always_ff @(posedge clk) begin
            if (rst) begin
                run_len <= 0;
            end else if (ctl_wr && wr_data[i]) begin
                run_len <= 0;
            end else if (clr_pulse[i]) begin
                run_len <= run_len + 1;
            end
        end

        assert_clear_starts_R3: assert property (@(posedge clk) disable iff (rst)
            (ctl_wr && wr_data[i]) |=> (clr_pulse[i] && !evt_flag[i]));

        assert_pulse_len_R3: assert property (@(posedge clk) disable iff (rst)
            $fell(clr_pulse[i]) |-> (run_len == PULSE_CYC));

        assert_clear_wins_R4: assert property (@(posedge clk) disable iff (rst)
            clr_pulse[i] |-> !evt_flag[i]);

        assert_set_latches_R5: assert property (@(posedge clk) disable iff (rst)
            (evt_set[i] && !clr_pulse[i] && !(ctl_wr && wr_data[i])) |=> evt_flag[i]);
    end

    assert_mode_load_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_sel && wr_en) |=> (rd_data[RB_MODE] == $past(wr_data[B_MODE])));

    assert_extend_locked_R7: assert property (@(posedge clk) disable iff (rst)
        !(ctl_wr && rd_data[RB_MODE]) |=> $stable(rd_data[B_EXT]));

    assert_sticky_locked_R8: assert property (@(posedge clk) disable iff (rst)
        !(ctl_wr && rd_data[B_EXT]) |=> $stable(rd_data[B_PACE:B_ARM]));
endmodule

bind acq_ctl_reg acq_ctl_chk #(
    .CLK_MHZ  (CLK_MHZ),
    .PULSE_NS (PULSE_NS)
) u_acq_ctl_chk (.*);

// File: tb/test_acq_ctl_reg.sv
module test_acq_ctl_reg;
    localparam int CLK_MHZ  = 125;
    localparam int PULSE_NS = 1500;
    localparam int P        = (CLK_MHZ * PULSE_NS + 999) / 1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_sel = 1'b0, mode_sel = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] evt_set = 3'b000;
    logic [2:0] clr_pulse, evt_flag;
    logic       armed, post_mode, pacer_fast;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic       m_mode, m_ext;
    logic [2:0] m_up, m_flag;
    int         m_cnt [3];

    always #4 clk = ~clk;

    acq_ctl_reg #(.CLK_MHZ(CLK_MHZ), .PULSE_NS(PULSE_NS)) i_acq_ctl_reg (
        .clk(clk), .rst(rst), .ctl_sel(ctl_sel), .mode_sel(mode_sel),
        .wr_en(wr_en), .wr_data(wr_data), .evt_set(evt_set),
        .clr_pulse(clr_pulse), .evt_flag(evt_flag), .armed(armed),
        .post_mode(post_mode), .pacer_fast(pacer_fast), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_pulses();
        logic [2:0] p;
        for (int i = 0; i < 3; i++) p[i] = (m_cnt[i] != 0);
        return p;
    endfunction

    function automatic logic [7:0] exp_rb();
        return {m_up, m_ext, m_mode, m_flag};
    endfunction

    task automatic compare_all();
        chk("R2 R4 R5 event flags", {5'd0, evt_flag}, {5'd0, m_flag});
        chk("R3 clear pulses", {5'd0, clr_pulse}, {5'd0, exp_pulses()});
        chk("R6 mode bit", {7'd0, rd_data[3]}, {7'd0, m_mode});
        chk("R7 extend", {7'd0, rd_data[4]}, {7'd0, m_ext});
        chk("R8 sticky bits", {5'd0, rd_data[7:5]}, {5'd0, m_up});
        chk("R10 outputs", {5'd0, pacer_fast, post_mode, armed}, {5'd0, m_up});
        chk("R11 read-back", rd_data, exp_rb());
    endtask

    // one clock: model step from present inputs, then compare after the edge
    task automatic cycle();
        logic       hit, mh;
        logic       n_mode, n_ext;
        logic [2:0] n_up, n_flag;
        int         n_cnt [3];
        hit    = ctl_sel & wr_en;
        mh     = mode_sel & wr_en;
        n_mode = mh ? wr_data[4] : m_mode;
        n_ext  = (hit && m_mode) ? wr_data[4] : m_ext;
        n_up   = (hit && m_ext) ? wr_data[7:5] : m_up;
        for (int i = 0; i < 3; i++) begin
            logic clr;
            clr       = (hit && wr_data[i]) || (m_cnt[i] != 0);
            n_flag[i] = clr ? 1'b0 : (m_flag[i] | evt_set[i]);
            n_cnt[i]  = (hit && wr_data[i]) ? P : ((m_cnt[i] > 0) ? m_cnt[i] - 1 : 0);
        end
        @(posedge clk);
        #2;
        m_mode = n_mode; m_ext = n_ext; m_up = n_up; m_flag = n_flag;
        for (int i = 0; i < 3; i++) m_cnt[i] = n_cnt[i];
        compare_all();
    endtask

    task automatic idle(input int n);
        ctl_sel = 0; mode_sel = 0; wr_en = 0; wr_data = 8'h00; evt_set = 3'b000;
        for (int k = 0; k < n; k++) cycle();
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        ctl_sel = 1; mode_sel = 0; wr_en = 1; wr_data = d; evt_set = 3'b000;
        cycle();
        ctl_sel = 0; wr_en = 0; wr_data = 8'h00;
    endtask

    task automatic wr_mode(input logic [7:0] d);
        ctl_sel = 0; mode_sel = 1; wr_en = 1; wr_data = d; evt_set = 3'b000;
        cycle();
        mode_sel = 0; wr_en = 0; wr_data = 8'h00;
    endtask

    task automatic pulse_set(input logic [2:0] s);
        ctl_sel = 0; mode_sel = 0; wr_en = 0; evt_set = s;
        cycle();
        evt_set = 3'b000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_mode = 0; m_ext = 0; m_up = 3'b000; m_flag = 3'b000;
        for (int i = 0; i < 3; i++) m_cnt[i] = 0;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1 reset read-back", rd_data, 8'h00);
        chk("R1 reset pulses", {5'd0, clr_pulse}, 8'h00);
        rst = 0;
        idle(2);

        // R7/R8: locked while mode is 0
        wr_ctl(8'h10);
        wr_ctl(8'hF8);
        chk("R8 sticky stay locked in mode 0", {5'd0, rd_data[7:5]}, 8'h00);

        // R6 then the unlock order
        wr_mode(8'h10);
        wr_ctl(8'hE0);              // extend still 0 before: sticky untouched
        wr_ctl(8'h10);              // extend on
        wr_ctl(8'h98);              // pacer on, bit 3 ignored (R11)
        chk("R10 pacer fast", {7'd0, pacer_fast}, 8'h01);
        wr_ctl(8'h80);              // extend off, keep pacer
        wr_ctl(8'h60);              // locked again
        chk("R8 sticky after relock", {5'd0, rd_data[7:5]}, 8'h04);
        wr_mode(8'h00);
        wr_ctl(8'h10);              // mode 0: extend must stay 0
        chk("R7 extend ignored mode 0", {7'd0, rd_data[4]}, 8'h00);

        // R5, R2, R3, R4
        pulse_set(3'b111);
        idle(2);
        wr_ctl(8'h01);
        wr_ctl(8'h00);
        chk("R2 other flags untouched", {5'd0, evt_flag}, 8'h06);
        idle(5);
        pulse_set(3'b001);          // inside the pulse: clear wins (R4)
        idle(P - 8);                // reach the last pulse cycle
        pulse_set(3'b001);
        pulse_set(3'b001);          // first cycle after the pulse ends
        chk("R4 R5 set after pulse end", {7'd0, evt_flag[0]}, 8'h01);
        wr_ctl(8'h02);
        idle(20);
        wr_ctl(8'h02);              // restart mid-pulse (R3)
        idle(P + 3);

        // R9: clears on a write that also opens extend
        wr_mode(8'h10);
        pulse_set(3'b111);
        wr_ctl(8'h17);
        chk("R9 clears on extend write", {5'd0, evt_flag}, 8'h00);
        idle(P + 2);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            r        = $urandom_range(0, 99);
            wr_en    = (r < 45);
            ctl_sel  = (r < 35) || (r >= 60 && r < 70);
            mode_sel = (r >= 35 && r < 45);
            wr_data  = 8'($urandom);
            if (mode_sel) wr_data[4] = ($urandom_range(0, 3) != 0);
            if (ctl_sel && ($urandom_range(0, 3) != 0)) wr_data[2:0] = 3'b000;
            evt_set  = 3'($urandom) & 3'($urandom);
            cycle();
        end
        idle(P + 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule